// File: doc/BRIEF.md
# RAM Segment Sweep Address Generator

This block produces the read address for a waveform lookup memory that is divided into segments. Each segment is described by a control word that holds a first address, a last address, a step-period reload value and a 3-bit traversal mode. A down-counting period timer paces the address steps. On every restart the block captures the segment word that belongs to the currently selected profile. A restart happens on an update strobe or on a change of the profile select.

Five traversal modes are available. Direct switch keeps the address at the segment start. Ramp up climbs to the last address, and can optionally jump back once if the no-dwell flag is set. Pin-driven bidirectional mode uses profile select bit 0 as the direction. Continuous bidirectional mode bounces between the two ends. Continuous recirculate wraps from the last address back to the start. A one-cycle done pulse marks each step that lands on the last address. The memory contents, and whether the memory word drives frequency or phase, are handled outside this block.

Top module: `sweep_addr_gen`

## Requirements
- R1: After reset `ram_addr` is 0 and `addr_valid` and `seg_done` are 0. `addr_valid` rises on the first restart and then stays high.
- R2: Mode code 000 (direct switch) keeps `ram_addr` at the segment start for as long as the mode is active. Codes 101, 110 and 111 behave exactly like 000.
- R3: After a restart, the address changes at most once every `seg_rate`+1 cycles. The first step appears `seg_rate`+1 cycles after the cycle in which the restart loaded the start address.
- R4: Mode code 001 (ramp up) with `no_dwell` low steps +1 up to the last address and then holds there. `seg_done` is high for exactly one cycle, in the cycle the address first shows the last address.
- R5: In mode 001 with `no_dwell` high, the step that follows arrival at the last address returns the address to the segment start. The address then stays at the start.
- R6: Mode code 100 (recirculate) steps +1 and wraps from the last address to the start, indefinitely. `no_dwell` has no effect in this mode.
- R7: Mode code 010 (pin-driven bidirectional) steps +1 while `prof_sel[0]`=1 and -1 while `prof_sel[0]`=0. The address holds at the last address or the start, whichever it has reached. In this mode a change of `prof_sel` does not restart the sweep.
- R8: Mode code 011 (continuous bidirectional) steps from the start up to the last address, then down to the start, and repeats. `seg_done` pulses on each arrival at the last address.
- R9: A high `update`, or a change of `prof_sel` outside mode 010, restarts the sweep. The address shows the new `seg_begin` in the next cycle, and the new `seg_rate` sets the timing from then on. A restart takes priority over a step that falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_begin | input | ADDR_W | Start address of the selected segment |
| seg_final | input | ADDR_W | Last address of the selected segment (above the start) |
| seg_rate | input | RATE_W | Step-period reload value |
| seg_mode | input | 3 | Traversal mode code |
| prof_sel | input | 2 | Profile select; bit 0 is the direction in mode 010 |
| update | input | 1 | Restart strobe |
| no_dwell | input | 1 | Return-to-start flag for ramp-up mode |
| ram_addr | output | ADDR_W | Memory read address |
| addr_valid | output | 1 | High once a segment has been loaded |
| seg_done | output | 1 | One-cycle pulse when the address lands on the last address |

## Verification
A restart and a timer expiry can fall on the same clock edge. In that case the address must take the new segment start, and must not take the stepped value of the old sweep. The bench provokes this by counting cycles from a known restart and pulsing `update` exactly on the cycle of a scheduled step. It then checks that the address equals the new start, and that the next step comes a full new period later. The bench also checks that a direction-pin change in mode 010 lands on a step boundary without any restart taking effect. For this it moves the start input at the same time, so that a wrongly taken restart would show up at the address port.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    M_DIRECT = 3'b000,
    M_RAMP   = 3'b001,
    M_BIDIR  = 3'b010,
    M_CBIDIR = 3'b011,
    M_RECIRC = 3'b100
  } swp_mode_e;

  // Codes above the last defined mode fold onto direct switch
  function automatic swp_mode_e decode_mode(input logic [2:0] code);
    if (code > 3'b100) return M_DIRECT;
    return swp_mode_e'(code);
  endfunction

endpackage

// File: rtl/swp_rate_timer.sv
module swp_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] reload_val,
  output logic              expire
);

  logic [RATE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= reload_val;
    else if (cnt == '0)     cnt <= reload_val;
    else                    cnt <= cnt - 1'b1;
  end

  assign expire = !load && (cnt == '0);

  a_r3_reload_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == $past(reload_val)));

  a_r9_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(reload_val)));

endmodule

// File: rtl/swp_restart_det.sv
module swp_restart_det #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [SEL_W-1:0] prof_sel,
  input  logic             sel_is_dir,
  output logic             restart
);

  logic [SEL_W-1:0] sel_prev;
  logic             sel_changed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= '0;
    else        sel_prev <= prof_sel;
  end

  assign sel_changed = (prof_sel != sel_prev);
  assign restart     = update || (sel_changed && !sel_is_dir);

  a_r9_update_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> restart);

  a_r7_dir_mode_ignores_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_is_dir && !update) |-> !restart);

endmodule

// File: rtl/sweep_addr_gen.sv
module sweep_addr_gen
  import swp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] seg_begin,
  input  logic [ADDR_W-1:0] seg_final,
  input  logic [RATE_W-1:0] seg_rate,
  input  logic [2:0]        seg_mode,
  input  logic [1:0]        prof_sel,
  input  logic              update,
  input  logic              no_dwell,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              addr_valid,
  output logic              seg_done
);

  localparam int SEL_W = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              done;
    logic              run;
    logic              dir_up;
  } step_t;

  // Next-step arithmetic for every traversal mode
  function automatic step_t calc_step(
    input swp_mode_e         m,
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] f,
    input logic              up,
    input logic              pin_up,
    input logic              nd
  );
    step_t             s;
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] dec;
    inc      = a + 1'b1;
    dec      = a - 1'b1;
    s.addr   = a;
    s.done   = 1'b0;
    s.run    = 1'b1;
    s.dir_up = up;
    case (m)
      M_RAMP: begin
        if (a != f) begin
          s.addr = inc;
          s.done = (inc == f);
        end else begin
          s.run = 1'b0;
          if (nd) s.addr = b;
        end
      end
      M_BIDIR: begin
        if (pin_up) begin
          if (a != f) begin
            s.addr = inc;
            s.done = (inc == f);
          end
        end else if (a != b) begin
          s.addr = dec;
        end
      end
      M_CBIDIR: begin
        if (up) begin
          if (a != f) begin
            s.addr = inc;
            s.done = (inc == f);
          end else begin
            s.dir_up = 1'b0;
            s.addr   = dec;
          end
        end else begin
          if (a != b) begin
            s.addr = dec;
          end else begin
            s.dir_up = 1'b1;
            s.addr   = inc;
            s.done   = (inc == f);
          end
        end
      end
      M_RECIRC: begin
        if (a != f) begin
          s.addr = inc;
          s.done = (inc == f);
        end else begin
          s.addr = b;
        end
      end
      default: ;
    endcase
    return s;
  endfunction

  // Latched segment parameters
  logic [ADDR_W-1:0] begin_q;
  logic [ADDR_W-1:0] final_q;
  logic [RATE_W-1:0] rate_q;
  swp_mode_e         mode_q;
  logic              running;
  logic              dir_up;

  // Named internal events
  logic              restart;
  logic              expire;
  logic              step_en;
  logic [RATE_W-1:0] timer_val;
  step_t             nxt;

  swp_restart_det #(.SEL_W(SEL_W)) restart_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .update     (update),
    .prof_sel   (prof_sel),
    .sel_is_dir (mode_q == M_BIDIR),
    .restart    (restart)
  );

  assign timer_val = restart ? seg_rate : rate_q;

  swp_rate_timer #(.RATE_W(RATE_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (restart),
    .reload_val (timer_val),
    .expire     (expire)
  );

  assign step_en = expire && running;
  assign nxt     = calc_step(mode_q, ram_addr, begin_q, final_q, dir_up,
                             prof_sel[0], no_dwell);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      addr_valid <= 1'b0;
      seg_done   <= 1'b0;
      begin_q    <= '0;
      final_q    <= '0;
      rate_q     <= '0;
      mode_q     <= M_DIRECT;
      running    <= 1'b0;
      dir_up     <= 1'b1;
    end else begin
      seg_done <= 1'b0;
      if (restart) begin
        begin_q    <= seg_begin;
        final_q    <= seg_final;
        rate_q     <= seg_rate;
        mode_q     <= decode_mode(seg_mode);
        ram_addr   <= seg_begin;
        running    <= 1'b1;
        dir_up     <= 1'b1;
        addr_valid <= 1'b1;
      end else if (step_en) begin
        ram_addr <= nxt.addr;
        seg_done <= nxt.done;
        running  <= nxt.run;
        dir_up   <= nxt.dir_up;
      end
    end
  end

  a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> addr_valid);

  a_r2_direct_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DIRECT && !restart) |=> $stable(ram_addr));

  a_r3_no_step_between_expiries: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !expire) |=> $stable(ram_addr));

  a_r4_done_at_final: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |-> (ram_addr == final_q));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> !seg_done);

  a_r6_recirc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !restart && mode_q == M_RECIRC && ram_addr == final_q)
      |=> (ram_addr == begin_q));

  a_r9_restart_loads_begin: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ram_addr == $past(seg_begin) && !seg_done));

endmodule

// File: tb/sweep_addr_gen_tb.sv
module sweep_addr_gen_tb_top;

  localparam int ADDR_W = 10;
  localparam int RATE_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] seg_begin = '0;
  logic [ADDR_W-1:0] seg_final = '0;
  logic [RATE_W-1:0] seg_rate = '0;
  logic [2:0]        seg_mode = '0;
  logic [1:0]        prof_sel = '0;
  logic              update = 1'b0;
  logic              no_dwell = 1'b0;
  logic [ADDR_W-1:0] ram_addr;
  logic              addr_valid;
  logic              seg_done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sweep_addr_gen #(.ADDR_W(ADDR_W), .RATE_W(RATE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .seg_begin(seg_begin), .seg_final(seg_final),
    .seg_rate(seg_rate), .seg_mode(seg_mode), .prof_sel(prof_sel),
    .update(update), .no_dwell(no_dwell), .ram_addr(ram_addr),
    .addr_valid(addr_valid), .seg_done(seg_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait w negedges, then compare address and done flag
  task automatic step_chk(input int w, input string req, input int ea, input int ed);
    repeat (w) @(negedge clk);
    chk({req, " addr"}, int'(ram_addr), ea);
    chk({req, " done"}, int'(seg_done), ed);
  endtask

  // Drive a segment word and pulse update; returns at the first sample negedge
  task automatic start_seg(input int b, input int f, input int r, input logic [2:0] m);
    seg_begin = ADDR_W'(b);
    seg_final = ADDR_W'(f);
    seg_rate  = RATE_W'(r);
    seg_mode  = m;
    update    = 1'b1;
    @(negedge clk);
    update    = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset addr", int'(ram_addr), 0);
    chk("R1 reset valid", int'(addr_valid), 0);
    chk("R1 reset done", int'(seg_done), 0);
  endtask

  task automatic t_direct();
    start_seg(5, 9, 0, 3'b000);
    chk("R1 valid after restart", int'(addr_valid), 1);
    step_chk(0, "R2 direct start", 5, 0);
    step_chk(10, "R2 direct hold", 5, 0);
    start_seg(12, 20, 0, 3'b111);
    step_chk(0, "R2 code111 start", 12, 0);
    step_chk(8, "R2 code111 hold", 12, 0);
    start_seg(7, 20, 1, 3'b101);
    step_chk(9, "R2 code101 hold", 7, 0);
    chk("R1 valid sticky", int'(addr_valid), 1);
  endtask

  task automatic t_rate();
    start_seg(0, 3, 3, 3'b001);
    step_chk(0, "R3 start", 0, 0);
    step_chk(3, "R3 no early step", 0, 0);
    step_chk(1, "R3 step at rate+1", 1, 0);
    step_chk(3, "R3 between steps", 1, 0);
    step_chk(1, "R3 second step", 2, 0);
  endtask

  task automatic t_ramp();
    no_dwell = 1'b0;
    start_seg(4, 6, 1, 3'b001);
    step_chk(2, "R4 ramp", 5, 0);
    step_chk(2, "R4 land final", 6, 1);
    step_chk(1, "R4 done one cycle", 6, 0);
    step_chk(1, "R4 hold final", 6, 0);
    step_chk(6, "R4 still final", 6, 0);
  endtask

  task automatic t_ramp_nd();
    no_dwell = 1'b1;
    start_seg(4, 6, 1, 3'b001);
    step_chk(2, "R5 ramp", 5, 0);
    step_chk(2, "R5 land final", 6, 1);
    step_chk(2, "R5 back to start", 4, 0);
    step_chk(2, "R5 stopped", 4, 0);
    step_chk(4, "R5 still stopped", 4, 0);
    no_dwell = 1'b0;
  endtask

  task automatic t_recirc();
    no_dwell = 1'b1;
    start_seg(4, 6, 1, 3'b100);
    step_chk(2, "R6 recirc", 5, 0);
    step_chk(2, "R6 land final", 6, 1);
    step_chk(2, "R6 wrap", 4, 0);
    step_chk(2, "R6 again", 5, 0);
    step_chk(2, "R6 final again", 6, 1);
    no_dwell = 1'b0;
  endtask

  task automatic t_bidir();
    prof_sel = 2'b01;
    start_seg(4, 6, 1, 3'b010);
    step_chk(0, "R7 start", 4, 0);
    step_chk(2, "R7 up", 5, 0);
    step_chk(2, "R7 land final", 6, 1);
    step_chk(2, "R7 hold top", 6, 0);
    prof_sel = 2'b00;
    step_chk(2, "R7 down", 5, 0);
    step_chk(2, "R7 down start", 4, 0);
    step_chk(2, "R7 hold start", 4, 0);
    prof_sel  = 2'b11;
    seg_begin = ADDR_W'(2);
    step_chk(1, "R7 sel change no restart", 4, 0);
    step_chk(1, "R7 up after pin flip", 5, 0);
  endtask

  task automatic t_cbidir();
    prof_sel = 2'b00;
    start_seg(4, 6, 1, 3'b011);
    step_chk(2, "R8 up", 5, 0);
    step_chk(2, "R8 top", 6, 1);
    step_chk(2, "R8 down", 5, 0);
    step_chk(2, "R8 bottom", 4, 0);
    step_chk(2, "R8 up again", 5, 0);
    step_chk(2, "R8 top again", 6, 1);
  endtask

  task automatic t_restart();
    prof_sel = 2'b00;
    start_seg(4, 9, 3, 3'b001);
    step_chk(4, "R9 ramp step", 5, 0);
    prof_sel  = 2'b01;
    seg_begin = ADDR_W'(20);
    seg_final = ADDR_W'(25);
    seg_rate  = RATE_W'(1);
    step_chk(1, "R9 profile change restart", 20, 0);
    step_chk(2, "R9 new rate", 21, 0);
    @(negedge clk);
    seg_begin = ADDR_W'(30);
    seg_final = ADDR_W'(35);
    update    = 1'b1;
    @(negedge clk);
    update    = 1'b0;
    chk("R9 restart beats step", int'(ram_addr), 30);
    step_chk(1, "R9 hold after restart", 30, 0);
    step_chk(1, "R9 step after restart", 31, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_rate();
    t_ramp();
    t_ramp_nd();
    t_recirc();
    t_bidir();
    t_cbidir();
    t_restart();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule